// File: doc/BRIEF.md
# Two-Wire Slave Memory Controller

This block is a slave on a two-wire serial bus. It sits in front of a 256-byte register array that stands in for nonvolatile memory. SCL and SDA are sampled with the system clock and pass through a synchronizer. An edge detector then reports SCL rising and falling edges, START and STOP. A state machine decodes a control byte and serves five transfer types: byte write, page write, current-address read, random read and sequential read. SDA is driven as an open-drain pull-down request.

Written bytes are collected in an eight-slot page buffer. They reach the array only when the transfer closes with STOP. At that moment every kept byte commits in the same cycle, and a timed internal write cycle starts. While that cycle runs, the slave refuses its device address, so the master can poll for completion. A separate protection block sees the address of each incoming byte and returns a write-enable bit for it. A refused byte is still acknowledged but is not kept.

States: `S_IDLE` (bus released), `S_CTRL` (receiving the control byte), `S_CACK` (acknowledging it), `S_WADDR` / `S_AACK` (word address and its acknowledge), `S_WDATA` / `S_DACK` (write data and its acknowledge), `S_RDATA` (sending a byte), `S_RACK` (sampling the master's acknowledge) and `S_WAIT` (ignoring the bus). Transitions:
- START from any state goes to `S_CTRL`. STOP from any state goes to `S_IDLE`.
- The eighth SCL fall in `S_CTRL` goes to `S_CACK` on a match, otherwise to `S_WAIT`.
- The SCL fall that ends `S_CACK` goes to `S_RDATA` for a read, otherwise to `S_WADDR`.
- The write path runs `S_WADDR`→`S_AACK`→`S_WDATA`, then cycles `S_WDATA`↔`S_DACK`.
- The read path runs `S_RDATA`→`S_RACK`. From `S_RACK` it returns to `S_RDATA` on a master acknowledge, or goes to `S_WAIT` on a not-acknowledge.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset and after any STOP (SDA rising while SCL is high), the slave releases SDA and waits for a START. A START (SDA falling while SCL is high) begins reception of a control byte from any state. The slave changes its SDA drive only while SCL is low.
- R2: The control byte arrives MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `sel_i`. Bit 0 set to 1 means read and 0 means write. On a match the slave pulls SDA low for the ninth clock. On a mismatch it leaves SDA released until the next START.
- R3: A write carries a word address byte, then a data byte. Both are acknowledged, and after STOP a read of that address returns the data.
- R4: Up to eight data bytes may follow one word address. Each is acknowledged, and all of them are stored on STOP.
- R5: Page-write addresses keep bits 7..3 of the word address and advance only bits 2..0, wrapping inside the aligned 8-byte page. The byte at the next page's first address is untouched.
- R6: Data bytes of a transfer that ends with a repeated START, instead of STOP, are discarded. A write control byte plus word address with no data byte, closed by STOP, stores nothing and starts no write cycle.
- R7: A STOP that closes a write holding at least one data byte starts an internal write cycle of `WR_CYCLES` system clocks. During it, the control byte is not acknowledged. Once it ends, the control byte is acknowledged again.
- R8: An internal pointer holds the last accessed address plus one and wraps from FFh to 00h. It is kept between transfers, and a read without a preceding word address starts there.
- R9: A random read (write of the word address, repeated START, read control byte) starts at that word address. A sequential read returns incrementing addresses while the master acknowledges, wrapping from FFh to 00h.
- R10: A data byte for which `wr_allow_i` is low, while `wr_chk_addr_o` shows its address, is acknowledged but not stored.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sel_i | input | 3 | Device select pins compared with control bits 3..1 |
| wr_allow_i | input | 1 | Write enable for the address on `wr_chk_addr_o` |
| sda_low_o | output | 1 | 1 requests pulling SDA low (open drain) |
| wr_chk_addr_o | output | ADDR_W | Memory address of the data byte currently being received |

## Verification
Bus events reach the state machine three system clocks after a line moves: two synchronizer stages plus an edge register. Any drive change on SDA then follows one clock later, inside the SCL low phase. The bench holds SCL low for eight clocks and high for four, and samples SDA two clocks into each high phase. By that point every acknowledge or data bit due at the preceding SCL fall is settled.

The end of the write cycle is not timed to the clock in the bench. Instead, the first poll right after a write STOP must be refused (about 125 clocks in, against 200), and a later poll must be accepted. Every stored value is checked only through later bus reads, after the write cycle has ended.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CACK,
        S_WADDR,
        S_AACK,
        S_WDATA,
        S_DACK,
        S_RDATA,
        S_RACK,
        S_WAIT
    } twi_state_t;

    localparam logic [3:0] CTRL_CODE = 4'b1010;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/twi_bus_sense.sv
module twi_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_p <= scl_q[SYNC_STAGES-1];
            sda_p <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_q[SYNC_STAGES-1];
    assign sda_s     = sda_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_wcycle_timer.sv
module twi_wcycle_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (kick) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr_en,
    input  logic [$clog2(SLOTS)-1:0]  wr_slot,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      wr_keep,
    output logic [SLOTS*DATA_W-1:0]   slot_data,
    output logic [SLOTS-1:0]          slot_keep
);
    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_data[g*DATA_W +: DATA_W] <= '0;
                    slot_keep[g]                  <= 1'b0;
                end else if (clear) begin
                    slot_keep[g] <= 1'b0;
                end else if (wr_en && (wr_slot == g)) begin
                    slot_data[g*DATA_W +: DATA_W] <= wr_data;
                    slot_keep[g]                  <= wr_keep;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic                        commit,
    input  logic [ADDR_W-$clog2(SLOTS)-1:0] commit_page,
    input  logic [SLOTS*DATA_W-1:0]     commit_data,
    input  logic [SLOTS-1:0]            commit_keep
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SW    = $clog2(SLOTS);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (commit_keep[s]) begin
                    mem[{commit_page, SW'(s)}] <= commit_data[s*DATA_W +: DATA_W];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 8,
    parameter int WR_CYCLES   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        sel_i,
    input  logic              wr_allow_i,
    output logic              sda_low_o,
    output logic [ADDR_W-1:0] wr_chk_addr_o
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int GW = ADDR_W - PW;

    twi_state_t state, nstate;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [ADDR_W-1:0] ptr;
    logic [GW-1:0]     page;
    logic [PW-1:0]     off;
    logic              pend;
    logic              m_ack;
    logic              sda_low;
    logic              busy;
    logic              byte_done;
    logic              ctrl_hit;
    logic              commit;
    logic              buf_wr;
    logic              buf_clear;
    logic              rd_load;
    logic [BYTE_W-1:0] rd_data;
    logic [PAGE_BYTES*BYTE_W-1:0] buf_data;
    logic [PAGE_BYTES-1:0]        buf_keep;
    logic              bus_evt;

    twi_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign bus_evt   = start_det | stop_det;
    assign byte_done = scl_fall && (bitcnt == 4'd8) && !bus_evt;
    assign ctrl_hit  = (shreg[7:4] == CTRL_CODE) && (shreg[3:1] == sel_i) && !busy;
    assign commit    = stop_det && pend;
    assign buf_clear = start_det | commit;
    assign buf_wr    = (state == S_WDATA) && byte_done;
    assign rd_load   = scl_fall && !bus_evt &&
                       (((state == S_CACK) && shreg[0]) || ((state == S_RACK) && m_ack));
    assign wr_chk_addr_o = {page, off};
    assign sda_low_o     = sda_low;

    twi_wcycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (commit),
        .busy  (busy)
    );

    twi_page_buf #(.SLOTS(PAGE_BYTES), .DATA_W(BYTE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (buf_wr),
        .wr_slot   (off),
        .wr_data   (shreg),
        .wr_keep   (wr_allow_i),
        .slot_data (buf_data),
        .slot_keep (buf_keep)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .SLOTS(PAGE_BYTES)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (ptr),
        .rd_data     (rd_data),
        .commit      (commit),
        .commit_page (page),
        .commit_data (buf_data),
        .commit_keep (buf_keep)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next-state decode
    always_comb begin
        nstate = state;
        if (start_det) begin
            nstate = S_CTRL;
        end else if (stop_det) begin
            nstate = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_WAIT: nstate = state;
                S_CTRL:  if (byte_done) nstate = ctrl_hit ? S_CACK : S_WAIT;
                S_CACK:  if (scl_fall)  nstate = shreg[0] ? S_RDATA : S_WADDR;
                S_WADDR: if (byte_done) nstate = S_AACK;
                S_AACK:  if (scl_fall)  nstate = S_WDATA;
                S_WDATA: if (byte_done) nstate = S_DACK;
                S_DACK:  if (scl_fall)  nstate = S_WDATA;
                S_RDATA: if (byte_done) nstate = S_RACK;
                S_RACK:  if (scl_fall)  nstate = m_ack ? S_RDATA : S_WAIT;
                default: nstate = S_IDLE;
            endcase
        end
    end

    // datapath and bus drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            page    <= '0;
            off     <= '0;
            pend    <= 1'b0;
            m_ack   <= 1'b0;
            sda_low <= 1'b0;
        end else if (bus_evt) begin
            bitcnt  <= '0;
            sda_low <= 1'b0;
            pend    <= 1'b0;
        end else begin
            unique case (state)
                S_CTRL, S_WADDR, S_WDATA: begin
                    if (scl_rise && (bitcnt < 4'd8)) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt  <= '0;
                        sda_low <= (state == S_CTRL) ? ctrl_hit : 1'b1;
                        if (state == S_WADDR) begin
                            ptr  <= shreg[ADDR_W-1:0];
                            page <= shreg[ADDR_W-1:PW];
                            off  <= shreg[PW-1:0];
                        end
                        if (state == S_WDATA) begin
                            pend <= 1'b1;
                            ptr  <= {page, off} + ADDR_W'(1);
                            off  <= off + PW'(1);
                        end
                    end
                end
                S_CACK, S_AACK, S_DACK, S_RACK: begin
                    if ((state == S_RACK) && scl_rise) begin
                        m_ack <= ~sda_s;
                    end
                    if (scl_fall) begin
                        bitcnt  <= '0;
                        sda_low <= 1'b0;
                        if (rd_load) begin
                            shreg   <= rd_data;
                            ptr     <= ptr + ADDR_W'(1);
                            sda_low <= ~rd_data[BYTE_W-1];
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_low <= 1'b0;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_low <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                S_IDLE, S_WAIT: sda_low <= 1'b0;
                default: sda_low <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
    import twi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int GW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input twi_state_t        state,
    input logic              scl_s,
    input logic              stop_det,
    input logic              sda_low,
    input logic              busy,
    input logic              commit,
    input logic              rd_load,
    input logic [ADDR_W-1:0] ptr,
    input logic [GW-1:0]     page
);
    // R1: STOP always returns the machine to idle
    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE));

    // R1: the drive on SDA moves only while SCL is low
    a_r1_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_s);

    // R7: no control acknowledge while the write cycle runs
    a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CACK) |-> !busy);

    // R7: a commit starts the write cycle
    a_r7_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R5: the page stays fixed across a page write
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WDATA || state == S_DACK) &&
         ($past(state) == S_WDATA || $past(state) == S_DACK)) |-> $stable(page));

    // R8: each byte loaded for reading advances the pointer by one
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (ptr == $past(ptr) + ADDR_W'(1)));

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W), .GW(GW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_low  (sda_low),
    .busy     (busy),
    .commit   (commit),
    .rd_load  (rd_load),
    .ptr      (ptr),
    .page     (page)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;
    localparam int WRC        = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic prot_on = 1'b0;
    logic [2:0] sel = 3'b101;
    logic sda_low;
    logic [7:0] chk_addr;
    logic allow;
    logic sda_line;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;
    logic [7:0] dbuf [8];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_low;

    function automatic bit allow_fn(logic [7:0] a);
        return !(prot_on && (a[7:3] == 5'h1E));
    endfunction

    assign allow = allow_fn(chk_addr);

    twi_mem_slave #(.WR_CYCLES(WRC)) u_twi_mem_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sel_i         (sel),
        .wr_allow_i    (allow),
        .sda_low_o     (sda_low),
        .wr_chk_addr_o (chk_addr)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(P);
        scl_m = 1'b1; tick(P);
        sda_m = 1'b0; tick(P);
        scl_m = 1'b0; tick(P);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(P);
        scl_m = 1'b1; tick(P);
        sda_m = 1'b1; tick(P);
    endtask

    task automatic xfer_bit(input bit b, output bit r);
        tick(P);
        sda_m = b; tick(P);
        scl_m = 1'b1; tick(P/2);
        r = sda_line; tick(P/2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) xfer_bit(d[i], r);
        xfer_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, r);
            d[i] = r;
        end
        xfer_bit(!give_ack, r);
    endtask

    function automatic logic [7:0] ctrl(bit rd);
        return {4'hA, sel, rd};
    endfunction

    task automatic poll_ready(input bit first_busy);
        bit ack = 0;
        int tries = 0;
        for (int t = 0; t < 20; t++) begin
            bus_start();
            send_byte(ctrl(1'b0), ack);
            bus_stop();
            tries = t;
            if (t == 0 && first_busy) chk("R7 first poll refused", ack, 0);
            if (ack) break;
        end
        chk("R7 poll accepted after cycle", ack, 1);
        if (first_busy) chk("R7 ready within three polls", int'(tries <= 3), 1);
    endtask

    task automatic wr_txn(input logic [7:0] addr, input int n);
        bit ack;
        logic [7:0] a;
        bus_start();
        send_byte(ctrl(1'b0), ack); chk("R2 write control ack", ack, 1);
        send_byte(addr, ack);       chk("R3 word address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(dbuf[k], ack);
            chk("R4 R10 data byte ack", ack, 1);
        end
        bus_stop();
        for (int k = 0; k < n; k++) begin
            a = {addr[7:3], 3'(addr[2:0] + k)};
            if (allow_fn(a)) ref_mem[a] = dbuf[k];
            ref_ptr = a + 8'd1;
        end
        poll_ready(1'b1);
    endtask

    task automatic rd_txn(string tag, input bit rnd, input logic [7:0] addr, input int n);
        bit ack;
        logic [7:0] d;
        logic [7:0] base;
        bus_start();
        if (rnd) begin
            send_byte(ctrl(1'b0), ack); chk("R9 dummy write control ack", ack, 1);
            send_byte(addr, ack);       chk("R9 dummy write address ack", ack, 1);
            bus_start();
            base = addr;
        end else begin
            base = ref_ptr;
        end
        send_byte(ctrl(1'b1), ack); chk("R2 read control ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(tag, d, ref_mem[8'(base + k)]);
        end
        tick(P);
        chk("R11 released after master nack", sda_line, 1);
        bus_stop();
        ref_ptr = 8'(base + n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        ref_ptr = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R1 reset releases SDA", sda_low, 0);

        // R2: select mismatch, code mismatch, then a match
        bus_start();
        send_byte({4'hA, ~sel, 1'b1}, ack); chk("R2 select mismatch nack", ack, 0);
        recv_byte(1'b0, d);                 chk("R2 ignored after mismatch", d, 8'hFF);
        bus_stop();
        bus_start();
        send_byte({4'hB, sel, 1'b0}, ack);  chk("R2 code mismatch nack", ack, 0);
        bus_stop();
        chk("R1 idle after stop", sda_low, 0);

        // R3: byte write then random read
        dbuf[0] = 8'h5A;
        wr_txn(8'h23, 1);
        rd_txn("R3 byte read back", 1'b1, 8'h23, 1);

        // R4: full page write, sequential read
        for (int k = 0; k < 8; k++) dbuf[k] = 8'(8'hC0 + k * 3);
        wr_txn(8'h40, 8);
        rd_txn("R4 page read back", 1'b1, 8'h40, 8);

        // R5: roll inside the page
        for (int k = 0; k < 4; k++) dbuf[k] = 8'(8'h71 + k);
        wr_txn(8'h56, 4);
        rd_txn("R5 page rollover contents", 1'b1, 8'h50, 9);

        // R6: data followed by repeated START is discarded
        bus_start();
        send_byte(ctrl(1'b0), ack);
        send_byte(8'h23, ack);
        send_byte(8'h99, ack);
        bus_start();
        send_byte(ctrl(1'b0), ack);
        send_byte(8'h23, ack);
        bus_stop();
        bus_start();
        send_byte(ctrl(1'b0), ack); chk("R6 no write cycle after discard", ack, 1);
        bus_stop();
        rd_txn("R6 discarded byte not stored", 1'b1, 8'h23, 1);

        // R8: pointer wraps after writing FFh; current-address read
        dbuf[0] = 8'h11;
        wr_txn(8'hFF, 1);
        chk("R8 pointer wrapped to zero", ref_ptr, 8'h00);
        rd_txn("R8 current address read", 1'b0, 8'h00, 1);
        rd_txn("R8 pointer persists", 1'b0, 8'h00, 2);

        // R9: sequential read across the top
        rd_txn("R9 sequential wrap", 1'b1, 8'hFE, 4);

        // R10: protected bytes acknowledged, not stored
        prot_on = 1'b1;
        for (int k = 0; k < 3; k++) dbuf[k] = 8'hEE;
        wr_txn(8'hF0, 3);
        rd_txn("R10 protected bytes unchanged", 1'b1, 8'hF0, 3);
        prot_on = 1'b0;

        // random mix
        for (int it = 0; it < 20; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            if (it % 5 == 0) a[7:3] = 5'h1E;
            n = 1 + int'($urandom % 8);
            prot_on = ($urandom % 3) == 0;
            for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
            wr_txn(a, n);
            prot_on = 1'b0;
            if ($urandom % 2 == 0)
                rd_txn("R9 R10 random read", 1'b1, {a[7:3], 3'b000}, 8);
            else
                rd_txn("R8 random current read", 1'b0, 8'h00, 1 + int'($urandom % 8));
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule